// File: doc/BRIEF.md
# Four-Context Issue Thread Picker

This block decides, on every clock, which of several hardware thread contexts hands its waiting instruction pair to the decoder. Each context owns a small ready buffer. The buffer's occupancy arrives as a per-context count input, and the picker keeps its own record of whether that buffer holds valid instructions since the last flush. A context is skipped when its buffer is empty or flushed, when it is asleep on a memory stall, or when it issued on the previous clock. Among the contexts that remain, a rotating pointer picks the winner, starting just past the context that issued most recently.

The same block steers refills from the instruction cache. The context that is issuing always gets the refill request for that cycle. In a cycle with no issue, the request goes to an idle context whose buffer needs loading. Several events change a context's state: a control-transfer redirect flushes its buffer, a memory stall flushes it and puts it to sleep until a wake strobe arrives, and a refill-complete strobe marks its buffer loaded again. An external fetch model returns each refill some cycles after the request.

Top module: `thread_picker`

## Requirements
- R1: Synchronous active-high reset clears both output valids, marks every buffer unloaded with no refill outstanding and no context asleep, and sets the rotating pointer to context 0.
- R2: A context can issue only when its count field is nonzero and a refill completion has loaded its buffer since its last flush. The count field for context t sits at bits [2t+1:2t] of `rdy_cnt_i`.
- R3: A context that issued in one cycle is never chosen in the following cycle.
- R4: The search for a winner starts at the context after the most recent issuer and wraps from the last context to 0. Contexts that cannot issue are passed over.
- R5: Whenever a context issues, `refill_vld_o` is high in the same output cycle and `refill_tid_o` equals `issue_tid_o`.
- R6: In a cycle with no issue, the refill request goes to the lowest-numbered context that is unloaded, awake and has no refill outstanding. When no context qualifies, no request is made.
- R7: A redirect makes its context ineligible in that cycle, unloads its buffer and cancels any outstanding refill, so that the context is requested again. A redirect outranks a refill completion for the same context in the same cycle.
- R8: A stall affects only its own context: it unloads the buffer, cancels any outstanding refill and puts the context to sleep. A sleeping context neither issues nor receives a request until it is woken. After a wake it is requested again.
- R9: When no context is eligible, `issue_vld_o` is low for that cycle and the rotating pointer keeps its value.
- R10: A refill completion for a context with no outstanding request has no effect.
- R11: When a stall and a wake reach the same context in the same cycle, the stall wins and the context stays asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy_cnt_i | input | NCTX*CNT_W | Per-context ready-buffer occupancy, context t at [t*CNT_W +: CNT_W] |
| stall_i | input | NCTX | Per-context memory stall (flush and sleep) |
| wake_i | input | NCTX | Per-context data-return wake |
| redir_vld_i | input | 1 | Control transfer to an unbuffered target |
| redir_tid_i | input | TID_W | Context of the redirect |
| fill_done_i | input | 1 | Refill-complete strobe from the fetch model |
| fill_tid_i | input | TID_W | Context of the completed refill |
| issue_vld_o | output | 1 | An instruction pair is sent to decode this cycle |
| issue_tid_o | output | TID_W | Issuing context |
| refill_vld_o | output | 1 | Refill request to the instruction cache |
| refill_tid_o | output | TID_W | Context to refill |

## Verification
Both output pairs are registered, so a result decided from the inputs present at a rising edge shows up just after that edge. The bench changes inputs on the falling edge and samples one time unit after the following rising edge. A refill completion that lands at edge k can first make its context issue at edge k+1, so the expected rows place every completion one row before the issue that depends on it. The no-repeat rule is checked both ways: the bench expects a bubble or a different context in the row after an issue, and property checks cover every cycle.

// File: rtl/tpick_pkg.sv
package tpick_pkg;

  // events that reach one context in a cycle
  typedef struct packed {
    logic stall;
    logic redir;
    logic wake;
    logic fill;
  } ctx_evt_t;

  // bookkeeping the picker keeps for one context
  typedef struct packed {
    logic loaded;
    logic pend;
    logic asleep;
  } ctx_flags_t;

endpackage

// File: rtl/tpick_ctx.sv
module tpick_ctx
  import tpick_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctx_evt_t   evt,
  input  logic       take,
  input  logic       bg_grant,
  output ctx_flags_t flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (evt.stall) begin
      flags.asleep <= 1'b1;
      flags.loaded <= 1'b0;
      flags.pend   <= 1'b0;
    end else begin
      if (evt.wake) flags.asleep <= 1'b0;
      if (evt.redir) begin
        flags.loaded <= 1'b0;
        flags.pend   <= 1'b0;
      end else begin
        if (evt.fill && flags.pend) begin
          flags.loaded <= 1'b1;
          flags.pend   <= 1'b0;
        end
        if (take || bg_grant) flags.pend <= 1'b1;
      end
    end
  end

  AST_TAKE_LOADED: assert property (@(posedge clk) disable iff (rst)
    take |-> (flags.loaded && !flags.asleep)); // R2
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (rst)
    bg_grant |-> (!flags.pend && !flags.loaded && !flags.asleep)); // R6
  AST_SLEEP_DRAINED: assert property (@(posedge clk) disable iff (rst)
    flags.asleep |-> (!flags.loaded && !flags.pend)); // R8
  AST_STRAY_FILL: assert property (@(posedge clk) disable iff (rst)
    (evt.fill && !flags.pend && !evt.stall && !evt.redir) |=> $stable(flags.loaded)); // R10

endmodule

// File: rtl/tpick_rr.sv
module tpick_rr #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  always_comb begin
    int p;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      p = (int'(start) + k) % N;
      if (!found && req[p]) begin
        found = 1'b1;
        idx   = IW'(p);
      end
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) onehot[j] = found && (idx == IW'(j));
  end

  AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (rst)
    found |-> req[idx]); // R4
  AST_NONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !found |-> (req == '0)); // R9

endmodule

// File: rtl/tpick_steer.sv
module tpick_steer #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_found,
  input  logic [IW-1:0] issue_idx,
  input  logic [N-1:0]  need,
  output logic          req_vld,
  output logic [IW-1:0] req_idx,
  output logic [N-1:0]  bg_grant
);

  always_comb begin
    req_vld  = issue_found;
    req_idx  = issue_idx;
    bg_grant = '0;
    if (!issue_found) begin
      for (int k = 0; k < N; k++) begin
        if (!req_vld && need[k]) begin
          req_vld     = 1'b1;
          req_idx     = IW'(k);
          bg_grant[k] = 1'b1;
        end
      end
    end
  end

  AST_BG_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bg_grant != '0) |-> (!issue_found && $onehot0(bg_grant))); // R6

endmodule

// File: rtl/thread_picker.sv
module thread_picker
  import tpick_pkg::*;
#(
  parameter int NCTX  = 4,
  parameter int SLOTS = 2,
  localparam int TID_W = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCTX*CNT_W-1:0] rdy_cnt_i,
  input  logic [NCTX-1:0]       stall_i,
  input  logic [NCTX-1:0]       wake_i,
  input  logic                  redir_vld_i,
  input  logic [TID_W-1:0]      redir_tid_i,
  input  logic                  fill_done_i,
  input  logic [TID_W-1:0]      fill_tid_i,
  output logic                  issue_vld_o,
  output logic [TID_W-1:0]      issue_tid_o,
  output logic                  refill_vld_o,
  output logic [TID_W-1:0]      refill_tid_o
);

  ctx_evt_t   evt [NCTX];
  ctx_flags_t flg [NCTX];

  logic [NCTX-1:0]  elig, need, take, bg_grant;
  logic             found, req_vld;
  logic [TID_W-1:0] win_idx, req_idx, rr_q;

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    logic redir_hit, fill_hit, last_hit, cnt_nz;

    assign redir_hit = redir_vld_i && (redir_tid_i == TID_W'(g));
    assign fill_hit  = fill_done_i && (fill_tid_i == TID_W'(g));
    assign last_hit  = issue_vld_o && (issue_tid_o == TID_W'(g));
    assign cnt_nz    = |rdy_cnt_i[g*CNT_W +: CNT_W];
    assign evt[g]    = {stall_i[g], redir_hit, wake_i[g], fill_hit};

    assign elig[g] = flg[g].loaded && !flg[g].asleep && cnt_nz &&
                     !stall_i[g] && !redir_hit && !last_hit;
    assign need[g] = !flg[g].loaded && !flg[g].asleep && !flg[g].pend &&
                     !stall_i[g] && !redir_hit;

    tpick_ctx u_ctx (
      .clk      (clk),
      .rst      (rst),
      .evt      (evt[g]),
      .take     (take[g]),
      .bg_grant (bg_grant[g]),
      .flags    (flg[g])
    );
  end

  tpick_rr #(.N(NCTX), .IW(TID_W)) u_rr (
    .clk    (clk),
    .rst    (rst),
    .req    (elig),
    .start  (rr_q),
    .found  (found),
    .idx    (win_idx),
    .onehot (take)
  );

  tpick_steer #(.N(NCTX), .IW(TID_W)) u_steer (
    .clk         (clk),
    .rst         (rst),
    .issue_found (found),
    .issue_idx   (win_idx),
    .need        (need),
    .req_vld     (req_vld),
    .req_idx     (req_idx),
    .bg_grant    (bg_grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_vld_o  <= 1'b0;
      issue_tid_o  <= '0;
      refill_vld_o <= 1'b0;
      refill_tid_o <= '0;
      rr_q         <= '0;
    end else begin
      issue_vld_o  <= found;
      issue_tid_o  <= win_idx;
      refill_vld_o <= req_vld;
      refill_tid_o <= req_idx;
      if (found) rr_q <= (win_idx == TID_W'(NCTX - 1)) ? '0 : win_idx + 1'b1;
    end
  end

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    issue_vld_o |=> !(issue_vld_o && issue_tid_o == $past(issue_tid_o))); // R3
  AST_REFILL_WITH_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue_vld_o |-> (refill_vld_o && refill_tid_o == issue_tid_o)); // R5
  AST_REDIRECT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    redir_vld_i |=> !(issue_vld_o && issue_tid_o == $past(redir_tid_i))); // R7

endmodule

// File: tb/thread_picker_test.sv
module thread_picker_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] rdy_cnt;
  logic [3:0] stall, wake;
  logic       rv, dv;
  logic [1:0] rt, dt;
  logic       issue_vld, refill_vld;
  logic [1:0] issue_tid, refill_tid;

  int total = 0;
  int bad = 0;
  int stepno = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  thread_picker uut (
    .clk          (clk),
    .rst          (rst),
    .rdy_cnt_i    (rdy_cnt),
    .stall_i      (stall),
    .wake_i       (wake),
    .redir_vld_i  (rv),
    .redir_tid_i  (rt),
    .fill_done_i  (dv),
    .fill_tid_i   (dt),
    .issue_vld_o  (issue_vld),
    .issue_tid_o  (issue_tid),
    .refill_vld_o (refill_vld),
    .refill_tid_o (refill_tid)
  );

  // {req, rst, cnt, stall, wake, redir, rtid, fill, ftid, exp_issue, exp_itid, exp_refill, exp_qtid}
  // count field for context t is cnt[2t+1:2t]; 8'hAA gives every context a count of 2
  localparam int NV = 36;
  localparam logic [32:0] TBL [NV] = '{
    {4'd6, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd0}, // 0  R6 first request ctx0
    {4'd6, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b1,2'd0, 1'b0,2'd0,1'b1,2'd1}, // 1  R6 pending ctx0 skipped
    {4'd2, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b1,2'd1, 1'b1,2'd0,1'b1,2'd0}, // 2  R2 loaded ctx0 issues
    {4'd3, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd1,1'b1,2'd1}, // 3  R3 ctx0 blocked
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd0,1'b1,2'd0}, // 4  R4 wrap to ctx0
    {4'd9, 1'b0,8'hA2,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd2}, // 5  R9 bubble, ctx1 count 0
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd1,1'b1,2'd1}, // 6  R4 pointer kept at 1
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b1,2'd2, 1'b1,2'd0,1'b1,2'd0}, // 7  R4
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd1,1'b1,2'd1}, // 8  R4
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd2,1'b1,2'd2}, // 9  R4
    {4'd7, 1'b0,8'hAA,4'b0000,4'b0000,1'b1,2'd0,1'b0,2'd0, 1'b1,2'd1,1'b1,2'd1}, // 10 R7 redirect ctx0
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd2,1'b1,2'd2}, // 11 R4
    {4'd7, 1'b0,8'hA2,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd0}, // 12 R7 ctx0 re-requested
    {4'd8, 1'b0,8'hAA,4'b0010,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd2,1'b1,2'd2}, // 13 R8 stall ctx1
    {4'd10,1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b1,2'd1, 1'b0,2'd0,1'b1,2'd3}, // 14 R10 stray fill ctx1
    {4'd3, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b1,2'd0, 1'b1,2'd2,1'b1,2'd2}, // 15 R3 after bubble
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd0,1'b1,2'd0}, // 16 R4
    {4'd8, 1'b0,8'hAA,4'b0000,4'b0010,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd2,1'b1,2'd2}, // 17 R8 wake ctx1
    {4'd10,1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd0,1'b1,2'd0}, // 18 R10 ctx1 not loaded
    {4'd8, 1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd1}, // 19 R8 woken ctx1 requested
    {4'd6, 1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b0,2'd0}, // 20 R6 nothing to request
    {4'd2, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b1,2'd3, 1'b1,2'd2,1'b1,2'd2}, // 21 R2 fill not yet visible
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd3,1'b1,2'd3}, // 22 R4
    {4'd11,1'b0,8'hAA,4'b0001,4'b0001,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd2,1'b1,2'd2}, // 23 R11 stall+wake ctx0
    {4'd5, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd3,1'b1,2'd3}, // 24 R5
    {4'd11,1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd2,1'b1,2'd2}, // 25 R11 ctx0 asleep
    {4'd11,1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b0,2'd0}, // 26 R11 no request
    {4'd1, 1'b1,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b0,2'd0}, // 27 R1 reset
    {4'd1, 1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd0}, // 28 R1
    {4'd6, 1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd1}, // 29 R6
    {4'd6, 1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd2}, // 30 R6
    {4'd6, 1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd3}, // 31 R6
    {4'd2, 1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b1,2'd3, 1'b0,2'd0,1'b0,2'd0}, // 32 R2 count 0 holds
    {4'd2, 1'b0,8'h00,4'b0000,4'b0000,1'b0,2'd0,1'b1,2'd0, 1'b0,2'd0,1'b0,2'd0}, // 33 R2
    {4'd1, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd0,1'b1,2'd0}, // 34 R1 pointer at 0
    {4'd4, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd3,1'b1,2'd3}  // 35 R4
  };

  task automatic step(input logic [32:0] v);
    logic [3:0] rq;
    logic       r, eiv, eq;
    logic [7:0] c;
    logic [3:0] s, w;
    logic       xrv, xdv;
    logic [1:0] xrt, xdt, eit, eqt;
    logic       ok;
    {rq, r, c, s, w, xrv, xrt, xdv, xdt, eiv, eit, eq, eqt} = v;
    @(negedge clk);
    rst = r; rdy_cnt = c; stall = s; wake = w;
    rv = xrv; rt = xrt; dv = xdv; dt = xdt;
    @(posedge clk);
    #1;
    ok = (issue_vld == eiv) && (!eiv || issue_tid == eit) &&
         (refill_vld == eq) && (!eq || refill_tid == eqt);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d step %0d: actual issue=%0b/%0d refill=%0b/%0d expected issue=%0b/%0d refill=%0b/%0d",
               rq, stepno, issue_vld, issue_tid, refill_vld, refill_tid, eiv, eit, eq, eqt);
    end
    stepno++;
  endtask

  initial begin
    rst = 1'b1; rdy_cnt = 8'h00; stall = '0; wake = '0;
    rv = 1'b0; rt = '0; dv = 1'b0; dt = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the ports
    total++;
    if (issue_vld !== 1'b0 || refill_vld !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: actual issue=%0b refill=%0b expected issue=0 refill=0",
               issue_vld, refill_vld);
    end
    for (int i = 0; i < NV; i++) step(TBL[i]);
    // R7: redirect and fill on ctx0 together, redirect wins
    step({4'd7, 1'b0,8'hAA,4'b0000,4'b0000,1'b1,2'd0,1'b1,2'd0, 1'b0,2'd0,1'b0,2'd0});
    step({4'd7, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b1,2'd3,1'b1,2'd3});
    step({4'd7, 1'b0,8'hAA,4'b0000,4'b0000,1'b0,2'd0,1'b0,2'd0, 1'b0,2'd0,1'b1,2'd0});
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R0 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule